// File: doc/BRIEF.md
# Per-Core Low-Power Mode Sequencer

This block sits beside one CPU core and walks it into and out of a low-power state each time the core signals that it has executed a wait-for-interrupt. Four modes can be programmed. Standby only stops the core clock. Retention stops the clock and also asks for the core voltage to drop to the level that still keeps register contents. Standalone power-down puts the core in reset and opens its supply switch, without involving any other core. Coordinated power-down does the same as standalone power-down and, while the core is off, also tells the rest of the system that deeper system sleep is allowed.

Every sequence waits for a wake interrupt, then undoes its entry steps in the reverse order. Supply comes back first, followed by a programmable settle delay. Reset is then released, so a powered-down core warm-boots. The clock is ungated last. The core is let go only when the cache hierarchy reports that it is ready. A wake that arrives during entry cuts the entry short and jumps to the matching exit step.

The mode register can only be written while the sequencer is idle. After any sequence completes, the mode falls back to standby. A step code and a one-cycle done pulse report progress.

Top module: `core_idle_seq`

## Requirements
- R1: While reset is asserted and after its release: step_o is 0 (idle), clk_gate_o=0, ret_vreq_o=0, pwr_on_o=1, core_rst_o=0, deep_req_o=0, done_o=0, and mode_o is 0 (standby).
- R2: Mode encoding is 0 standby, 1 retention, 2 standalone power-down, 3 coordinated power-down. A write with mode_wr_i=1 updates mode_o on the next cycle only when step_o is 0. A write made while step_o is nonzero is ignored.
- R3: Standby: wfi_i in idle leads to step 1 (clock gated) and then to step 5 (waiting). A wake leads to step 9 (clock ungated) and then to step 10. Supply stays on and reset stays deasserted throughout.
- R4: Retention: step 1 is followed by step 2, where ret_vreq_o=1 while the clock stays gated. This holds through step 5. On wake the sequencer goes to step 8, where the voltage request is dropped while the clock stays gated. It then goes to step 9.
- R5: Standalone power-down: the entry steps are 1, then 3 (core_rst_o=1), then 4 (pwr_on_o=0), then 5. The exit steps are 6 (supply on, reset held), then 7 (reset released, clock still gated), then 9, then 10. deep_req_o stays 0.
- R6: Coordinated power-down follows the same steps as R5, and deep_req_o=1 exactly while it is in step 5.
- R7: Steps 6 and 8 each last settle_i+1 cycles. settle_i is sampled on entry to the step.
- R8: A wake seen during an entry step jumps to that step's exit counterpart on the next cycle: 1 to 9, 2 to 8, 3 to 7, 4 to 6.
- R9: When a sequence completes, mode_o returns to 0 (standby).
- R10: Step codes are 0 idle, 1 gate, 2 voltage down, 3 reset, 4 supply off, 5 wait, 6 supply on, 7 reset release, 8 voltage up, 9 ungate, 10 cache wait. done_o is high for exactly one cycle, the first idle cycle after a sequence.
- R11: In step 10 the clock is ungated. The sequencer holds in step 10 until cache_ready_i=1 and then returns to idle.
- R12: If wfi_i and a mode write arrive in the same idle cycle, the write is ignored and the sequence runs in the previously programmed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_i | input | 1 | Core has executed wait-for-interrupt |
| wake_irq_i | input | 1 | Wake interrupt |
| cache_ready_i | input | 1 | Cache hierarchy ready acknowledge |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 2 | Mode to program |
| settle_i | input | SETTLE_W | Settle delay count for supply and voltage ramp-up |
| clk_gate_o | output | 1 | 1 = core clock gated |
| ret_vreq_o | output | 1 | 1 = request retention voltage |
| pwr_on_o | output | 1 | 1 = core supply switch closed |
| core_rst_o | output | 1 | 1 = core held in reset |
| deep_req_o | output | 1 | 1 = system deeper sleep permitted |
| step_o | output | 4 | Current step code |
| done_o | output | 1 | One-cycle pulse on return to active |
| mode_o | output | 2 | Programmed mode |

## Verification
Two pairs of events can land in the same cycle. The first pair is the idle-time mode write and the wait-for-interrupt start. The bench drives both on one edge and judges the result from mode_o and from the step path that follows, which must be the path of the old mode. The second pair is a wake and an entry step. The bench raises the wake on the very cycle that each of steps 1 to 4 is shown, and expects the matching exit step code one cycle later, with the power outputs in a safe state.

// File: rtl/core_idle_pkg.sv
package core_idle_pkg;

  typedef enum logic [1:0] {
    MODE_STBY  = 2'd0,
    MODE_RET   = 2'd1,
    MODE_SOLO  = 2'd2,
    MODE_COORD = 2'd3
  } lpm_mode_t;

  localparam int unsigned STEP_W = 4;

  typedef enum logic [STEP_W-1:0] {
    ST_IDLE   = 4'd0,
    ST_GATE   = 4'd1,
    ST_VDOWN  = 4'd2,
    ST_RST    = 4'd3,
    ST_PWROFF = 4'd4,
    ST_WAIT   = 4'd5,
    ST_PWRON  = 4'd6,
    ST_UNRST  = 4'd7,
    ST_VUP    = 4'd8,
    ST_UNGATE = 4'd9,
    ST_CACHE  = 4'd10
  } lpm_step_t;

  function automatic logic mode_is_pd(lpm_mode_t m);
    return (m == MODE_SOLO) || (m == MODE_COORD);
  endfunction

endpackage

// File: rtl/core_idle_rst_sync.sv
module core_idle_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/core_idle_mode_reg.sv
module core_idle_mode_reg
  import core_idle_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en_i,
  input  lpm_mode_t wr_mode_i,
  input  logic      seq_idle_i,
  input  logic      seq_start_i,
  input  logic      seq_finish_i,
  output lpm_mode_t mode_o
);
  lpm_mode_t mode_q, mode_d;
  logic      mode_en;

  always_comb begin
    mode_en = 1'b0;
    mode_d  = mode_q;
    if (seq_finish_i) begin
      mode_en = 1'b1;
      mode_d  = MODE_STBY;
    end else if (wr_en_i && seq_idle_i && !seq_start_i) begin
      mode_en = 1'b1;
      mode_d  = wr_mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_STBY;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/core_idle_settle.sv
module core_idle_settle #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || dec_i;
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/core_idle_fsm.sv
module core_idle_fsm
  import core_idle_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wfi_i,
  input  logic      wake_i,
  input  logic      cache_ready_i,
  input  lpm_mode_t mode_i,
  input  logic      settle_zero_i,
  output lpm_step_t step_o,
  output logic      start_o,
  output logic      finish_o,
  output logic      settle_load_o,
  output logic      settle_dec_o,
  output logic      done_o,
  output logic      clk_gate_o,
  output logic      ret_vreq_o,
  output logic      pwr_on_o,
  output logic      core_rst_o,
  output logic      deep_req_o
);
  lpm_step_t step_q, step_d;
  logic      done_q;
  logic      is_pd;

  assign is_pd = mode_is_pd(mode_i);

  // next-step selection
  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:   if (wfi_i) step_d = ST_GATE;
      ST_GATE: begin
        if (wake_i)                 step_d = ST_UNGATE;
        else if (mode_i == MODE_RET) step_d = ST_VDOWN;
        else if (is_pd)             step_d = ST_RST;
        else                        step_d = ST_WAIT;
      end
      ST_VDOWN:  step_d = wake_i ? ST_VUP   : ST_WAIT;
      ST_RST:    step_d = wake_i ? ST_UNRST : ST_PWROFF;
      ST_PWROFF: step_d = wake_i ? ST_PWRON : ST_WAIT;
      ST_WAIT: begin
        if (wake_i) begin
          if (is_pd)                   step_d = ST_PWRON;
          else if (mode_i == MODE_RET) step_d = ST_VUP;
          else                         step_d = ST_UNGATE;
        end
      end
      ST_PWRON:  if (settle_zero_i) step_d = ST_UNRST;
      ST_UNRST:  step_d = ST_UNGATE;
      ST_VUP:    if (settle_zero_i) step_d = ST_UNGATE;
      ST_UNGATE: step_d = ST_CACHE;
      ST_CACHE:  if (cache_ready_i) step_d = ST_IDLE;
      default:   step_d = ST_IDLE;
    endcase
  end

  always_comb begin
    start_o       = (step_q == ST_IDLE) && wfi_i;
    finish_o      = (step_q == ST_CACHE) && cache_ready_i;
    settle_load_o = ((step_d == ST_PWRON) && (step_q != ST_PWRON)) ||
                    ((step_d == ST_VUP)   && (step_q != ST_VUP));
    settle_dec_o  = ((step_q == ST_PWRON) || (step_q == ST_VUP)) && !settle_zero_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= finish_o;
    end
  end

  // output decode: each entry step applies its action, each exit step undoes it
  always_comb begin
    clk_gate_o = 1'b0;
    ret_vreq_o = 1'b0;
    core_rst_o = 1'b0;
    pwr_on_o   = 1'b1;
    deep_req_o = 1'b0;
    unique case (step_q)
      ST_GATE, ST_RST, ST_UNRST, ST_VUP: clk_gate_o = 1'b1;
      ST_VDOWN: begin
        clk_gate_o = 1'b1;
        ret_vreq_o = 1'b1;
      end
      ST_PWROFF: begin
        clk_gate_o = 1'b1;
        pwr_on_o   = 1'b0;
      end
      ST_WAIT: begin
        clk_gate_o = 1'b1;
        ret_vreq_o = (mode_i == MODE_RET);
        pwr_on_o   = !is_pd;
        deep_req_o = (mode_i == MODE_COORD);
      end
      ST_PWRON:  clk_gate_o = 1'b1;
      default: ;
    endcase
    core_rst_o = is_pd && ((step_q == ST_RST) || (step_q == ST_PWROFF) ||
                           (step_q == ST_WAIT) || (step_q == ST_PWRON));
  end

  assign step_o = step_q;
  assign done_o = done_q;
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import core_idle_pkg::*;
#(
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wfi_i,
  input  logic                wake_irq_i,
  input  logic                cache_ready_i,
  input  logic                mode_wr_i,
  input  logic [1:0]          mode_wdata_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                clk_gate_o,
  output logic                ret_vreq_o,
  output logic                pwr_on_o,
  output logic                core_rst_o,
  output logic                deep_req_o,
  output logic [STEP_W-1:0]   step_o,
  output logic                done_o,
  output logic [1:0]          mode_o
);
  logic      rst_int_n;
  lpm_mode_t mode_q;
  lpm_step_t step;
  logic      seq_start, seq_finish;
  logic      settle_load, settle_dec, settle_zero;

  core_idle_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  core_idle_mode_reg u_mode (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr_en_i      (mode_wr_i),
    .wr_mode_i    (lpm_mode_t'(mode_wdata_i)),
    .seq_idle_i   (step == ST_IDLE),
    .seq_start_i  (seq_start),
    .seq_finish_i (seq_finish),
    .mode_o       (mode_q)
  );

  core_idle_settle #(.CNT_W(SETTLE_W)) u_settle (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (settle_load),
    .load_val_i (settle_i),
    .dec_i      (settle_dec),
    .zero_o     (settle_zero)
  );

  core_idle_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .wfi_i         (wfi_i),
    .wake_i        (wake_irq_i),
    .cache_ready_i (cache_ready_i),
    .mode_i        (mode_q),
    .settle_zero_i (settle_zero),
    .step_o        (step),
    .start_o       (seq_start),
    .finish_o      (seq_finish),
    .settle_load_o (settle_load),
    .settle_dec_o  (settle_dec),
    .done_o        (done_o),
    .clk_gate_o    (clk_gate_o),
    .ret_vreq_o    (ret_vreq_o),
    .pwr_on_o      (pwr_on_o),
    .core_rst_o    (core_rst_o),
    .deep_req_o    (deep_req_o)
  );

  assign step_o = step;
  assign mode_o = mode_q;
endmodule

// File: rtl/core_idle_seq_chk.sv
module core_idle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cache_ready_i,
  input logic       clk_gate_o,
  input logic       ret_vreq_o,
  input logic       pwr_on_o,
  input logic       core_rst_o,
  input logic       deep_req_o,
  input logic [3:0] step_o,
  input logic       done_o,
  input logic [1:0] mode_o
);
  // R5: supply is never open unless the core is held in reset
  a_r5_off_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on_o |-> core_rst_o);

  // R5: a core in reset always has its clock gated
  a_r5_reset_gated: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> clk_gate_o);

  // R4: retention voltage only with the clock stopped
  a_r4_vret_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vreq_o |-> clk_gate_o);

  // R6: deep sleep permission only while the supply is off
  a_r6_deep_off: assert property (@(posedge clk) disable iff (!rst_n)
    deep_req_o |-> !pwr_on_o);

  // R10: done is a single-cycle pulse seen in idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (step_o == 4'd0));

  // R9: mode is back to standby when done is shown
  a_r9_revert: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mode_o == 2'd0));

  // R2: mode holds while a sequence is running and not finishing
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((step_o != 4'd0) && !((step_o == 4'd10) && cache_ready_i)) |=> $stable(mode_o));

  // R11: clock is running while waiting for the cache
  a_r11_cache_ungated: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o == 4'd10) |-> !clk_gate_o);
endmodule

bind core_idle_seq core_idle_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cache_ready_i (cache_ready_i),
  .clk_gate_o    (clk_gate_o),
  .ret_vreq_o    (ret_vreq_o),
  .pwr_on_o      (pwr_on_o),
  .core_rst_o    (core_rst_o),
  .deep_req_o    (deep_req_o),
  .step_o        (step_o),
  .done_o        (done_o),
  .mode_o        (mode_o)
);

// File: tb/core_idle_seq_test.sv
`timescale 1ns/1ps
module core_idle_seq_test;
  logic       clk, rst_n;
  logic       wfi, wake, cready, mwr;
  logic [1:0] mdata;
  logic [7:0] settle;
  logic       gate, vret, pwr, crst, deep, done;
  logic [3:0] step;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  core_idle_seq #(.SETTLE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wake_irq_i(wake),
    .cache_ready_i(cready), .mode_wr_i(mwr), .mode_wdata_i(mdata),
    .settle_i(settle), .clk_gate_o(gate), .ret_vreq_o(vret),
    .pwr_on_o(pwr), .core_rst_o(crst), .deep_req_o(deep),
    .step_o(step), .done_o(done), .mode_o(mode)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // out = {gate, vret, pwr, crst, deep}
  task automatic chk_out(string req, int exp_step, logic [4:0] exp_out);
    chk(req, "step", step, exp_step);
    chk(req, "outputs", {gate, vret, pwr, crst, deep}, exp_out);
  endtask

  task automatic program_mode(logic [1:0] m);
    mwr = 1; mdata = m;
    tick();
    mwr = 0;
    chk("R2", "mode after idle write", mode, m);
  endtask

  task automatic start_seq();
    wfi = 1;
    tick();
    wfi = 0;
  endtask

  task automatic finish_seq(string req);
    cready = 1;
    tick();
    cready = 0;
    chk(req, "idle after cache ready", step, 0);
    chk("R10", "done pulse", done, 1);
    chk("R9", "mode reverted", mode, 0);
    tick();
    chk("R10", "done cleared", done, 0);
  endtask

  task automatic test_reset();
    rst_n = 0; wfi = 0; wake = 0; cready = 0; mwr = 0; mdata = 0; settle = 0;
    repeat (3) tick();
    chk_out("R1", 0, 5'b00100);
    chk("R1", "mode in reset", mode, 0);
    chk("R1", "done in reset", done, 0);
    rst_n = 1;
    repeat (3) tick();
    chk_out("R1", 0, 5'b00100);
    chk("R1", "mode after reset", mode, 0);
  endtask

  task automatic test_standby();
    start_seq();
    chk_out("R3", 1, 5'b10100);
    tick();
    chk_out("R3", 5, 5'b10100);
    repeat (3) tick();
    chk_out("R3", 5, 5'b10100);
    wake = 1;
    tick();
    wake = 0;
    chk_out("R3", 9, 5'b00100);
    tick();
    chk_out("R11", 10, 5'b00100);
    repeat (4) tick();
    chk("R11", "held waiting cache", step, 10);
    chk("R10", "no done while busy", done, 0);
    finish_seq("R11");
  endtask

  task automatic test_retention();
    settle = 8'd3;
    program_mode(2'd1);
    start_seq();
    chk_out("R4", 1, 5'b10100);
    tick();
    chk_out("R4", 2, 5'b11100);
    tick();
    chk_out("R4", 5, 5'b11100);
    mwr = 1; mdata = 2'd3;
    wake = 1;
    tick();
    wake = 0; mwr = 0;
    chk("R2", "busy write ignored", mode, 1);
    chk_out("R4", 8, 5'b10100);
    repeat (3) begin
      tick();
      chk("R7", "voltage-up settle hold", step, 8);
    end
    tick();
    chk_out("R7", 9, 5'b00100);
    tick();
    finish_seq("R4");
  endtask

  task automatic test_solo();
    settle = 8'd2;
    program_mode(2'd2);
    start_seq();
    chk_out("R5", 1, 5'b10100);
    tick();
    chk_out("R5", 3, 5'b10110);
    tick();
    chk_out("R5", 4, 5'b10010);
    tick();
    chk_out("R5", 5, 5'b10010);
    wake = 1;
    tick();
    wake = 0;
    chk_out("R5", 6, 5'b10110);
    repeat (2) begin
      tick();
      chk("R7", "supply settle hold", step, 6);
    end
    tick();
    chk_out("R5", 7, 5'b10100);
    tick();
    chk_out("R5", 9, 5'b00100);
    tick();
    chk("R5", "cache wait", step, 10);
    finish_seq("R5");
  endtask

  task automatic test_coord();
    settle = 8'd0;
    program_mode(2'd3);
    start_seq();
    tick();
    chk_out("R6", 3, 5'b10110);
    tick();
    chk_out("R6", 4, 5'b10010);
    tick();
    chk_out("R6", 5, 5'b10011);
    wake = 1;
    tick();
    wake = 0;
    chk_out("R6", 6, 5'b10110);
    tick();
    chk_out("R7", 7, 5'b10100);
    tick();
    chk("R6", "ungate", step, 9);
    tick();
    finish_seq("R6");
  endtask

  task automatic abort_at(logic [1:0] m, int at_step, int exp_next, logic [4:0] exp_out);
    settle = 8'd1;
    program_mode(m);
    start_seq();
    for (int i = 0; i < 4 && step != at_step; i++) tick();
    chk("R8", "reached entry step", step, at_step);
    wake = 1;
    tick();
    wake = 0;
    chk_out("R8", exp_next, exp_out);
    for (int i = 0; i < 10 && step != 10; i++) tick();
    chk("R8", "exit reached cache wait", step, 10);
    finish_seq("R8");
  endtask

  task automatic test_collision();
    chk("R12", "mode before collision", mode, 0);
    wfi = 1; mwr = 1; mdata = 2'd2;
    tick();
    wfi = 0; mwr = 0;
    chk("R12", "write dropped", mode, 0);
    chk("R12", "started", step, 1);
    tick();
    chk_out("R12", 5, 5'b10100);
    wake = 1;
    tick();
    wake = 0;
    chk("R12", "standby exit", step, 9);
    tick();
    finish_seq("R12");
  endtask

  initial begin
    test_reset();
    test_standby();
    test_retention();
    test_solo();
    test_coord();
    abort_at(2'd2, 1, 9, 5'b00100);
    abort_at(2'd1, 2, 8, 5'b10100);
    abort_at(2'd2, 3, 7, 5'b10100);
    abort_at(2'd3, 4, 6, 5'b10110);
    test_collision();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule